// File: doc/BRIEF.md
# Quasi-Resonant Turn-On Trigger

This block decides the instant at which the power switch of a flyback converter is turned on. Two digitized comparator levels watch the demagnetization sense input. One is high while the sense voltage is above the arming level of about 110 mV. The other is high while the sense voltage is above the trigger level of about 60 mV. A rising arm level primes the block. The next falling trigger level then requests a turn-on, provided that the blanking window opened at the previous switch turn-off has expired.

The blanking window is derived from an 8-bit code for the control voltage. That code maps linearly from 0 V to 3.3 V, and time is counted in 10 MHz system clock cycles. A high control voltage gives a short window, so the switch turns on at the first valley. A low control voltage gives a long window, so ringing valleys are passed over. A starter timer provides turn-on pulses when no usable demagnetization edge arrives, for example during power-up or when the output is too low to arm the trigger. Its period depends on whether the control voltage is above or below the burst level.

The outputs are a one-cycle turn-on request for the gate driver logic and a flag that reports whether the switching cycle just ended skipped any valleys.

Top module: `qr_turnon_ctrl`

## Requirements
- R1: While reset is applied and afterwards until the first turn-on, `ton_req` and `valley_skip` are 0. The trigger is disarmed and no blanking window is active.
- R2: When the block is armed and the window is open, a falling `dmg_trig_hi` sampled at clock edge k makes `ton_req` high for exactly one cycle, starting at edge k.
- R3: A rising `dmg_arm_hi` arms the trigger, and every turn-on disarms it. A falling trigger level seen while disarmed causes no turn-on.
- R4: A single-cycle `sw_off` pulse sampled at edge E, arriving while the switch is on, blanks the falling edges sampled at edges E+1 to E+L. L is computed from `ctrl_code` sampled at E: L = 300 for a code of 70 or less, L = 60 for a code of 100 or more, and L = 300 - (code - 70) * 8 between those codes.
- R5: The first armed falling edge sampled after blanking has expired (from edge E+L+1 on) turns the switch on. Falling edges between a turn-on and the following `sw_off` are ignored.
- R6: At every turn-on, `valley_skip` is loaded with 1 if at least one armed falling edge was rejected by blanking since the previous turn-on, and with 0 otherwise. It holds that value until the next turn-on.
- R7: If no turn-on occurs for P cycles, the starter issues one. P = 1250 cycles (8 kHz) when `ctrl_code` is above 77 (1 V), and P = 5000 cycles (2 kHz) when it is 77 or less. The starter timer restarts on every turn-on, whatever its cause.
- R8: Two turn-on requests are never closer than 61 cycles, which keeps the switching rate below 166 kHz. The first request after reset also comes no earlier than 61 cycles. Falling edges that would break this spacing are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 10 MHz nominal |
| rst_n | input | 1 | Active-low synchronous reset |
| dmg_arm_hi | input | 1 | Sense input above arming level (synchronized) |
| dmg_trig_hi | input | 1 | Sense input above trigger level (synchronized) |
| ctrl_code | input | 8 | Control voltage code, 0 = 0 V, 255 = 3.3 V |
| sw_off | input | 1 | One-cycle pulse when the driver turns the switch off |
| ton_req | output | 1 | One-cycle turn-on request |
| valley_skip | output | 1 | Last switching cycle passed over at least one valley |

## Verification
The assertions take for granted that both comparator levels are already synchronized and free of glitches. They also assume that `sw_off` is a single-cycle pulse that follows a turn-on. Under those conditions each sampled transition is a genuine crossing, and the blanking window always begins from a real turn-off. The stimulus changes inputs only at mid-cycle, pulses `sw_off` for one cycle shortly after each turn-on, and changes `ctrl_code` only just after a turn-on. As a result, every starter period and blanking length it measures uses a single code value.

// File: rtl/qrt_pkg.sv
package qrt_pkg;

  typedef enum logic [1:0] {
    PH_OPEN  = 2'd0,
    PH_ON    = 2'd1,
    PH_BLANK = 2'd2
  } phase_t;

  // Blanking length in cycles: long at low control voltage, short at high,
  // straight line in between (floor division).
  function automatic int blank_len(input int code, input int lo, input int hi,
                                   input int bmax, input int bmin);
    if (code <= lo) return bmax;
    if (code >= hi) return bmin;
    return bmax - ((code - lo) * (bmax - bmin)) / (hi - lo);
  endfunction

  // Starter period in cycles: fast above the burst code, slow at or below.
  function automatic int starter_len(input int code, input int burst,
                                     input int fast, input int slow);
    return (code > burst) ? fast : slow;
  endfunction

endpackage

// File: rtl/qrt_edge_arm.sv
module qrt_edge_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_lvl,
  input  logic trig_lvl,
  input  logic fire,
  output logic armed,
  output logic rise_ev,
  output logic fall_ev
);
  logic arm_d;
  logic trig_d;

  always_comb begin
    rise_ev = arm_lvl & ~arm_d;
    fall_ev = trig_d & ~trig_lvl;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_d  <= 1'b0;
      trig_d <= 1'b0;
      armed  <= 1'b0;
    end else begin
      arm_d  <= arm_lvl;
      trig_d <= trig_lvl;
      if (fire)         armed <= 1'b0;
      else if (rise_ev) armed <= 1'b1;
    end
  end

  // R3: a turn-on always leaves the trigger disarmed
  a_r3_clear_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !armed);

  // R3: a rising arm crossing without a turn-on leaves it armed
  a_r3_set_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_ev && !fire) |=> armed);

endmodule

// File: rtl/qrt_blank_timer.sv
module qrt_blank_timer
  import qrt_pkg::*;
#(
  parameter int CODE_W        = 8,
  parameter int BLANK_LO_CODE = 70,
  parameter int BLANK_HI_CODE = 100,
  parameter int BLANK_MAX     = 300,
  parameter int BLANK_MIN     = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              sw_off,
  input  logic [CODE_W-1:0] code,
  output logic              win_open,
  output logic              in_blank
);
  localparam int BCW = $clog2(BLANK_MAX + 1);

  phase_t         phase;
  logic [BCW-1:0] cnt;
  logic [BCW-1:0] len_m1;

  always_comb begin
    len_m1   = BCW'(blank_len(int'(code), BLANK_LO_CODE, BLANK_HI_CODE,
                              BLANK_MAX, BLANK_MIN) - 1);
    win_open = (phase == PH_OPEN);
    in_blank = (phase == PH_BLANK);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_OPEN;
      cnt   <= '0;
    end else if (fire) begin
      phase <= PH_ON;
    end else begin
      unique case (phase)
        PH_ON: if (sw_off) begin
          phase <= PH_BLANK;
          cnt   <= len_m1;
        end
        PH_BLANK: if (cnt == '0) phase <= PH_OPEN;
                  else           cnt   <= cnt - 1'b1;
        default: phase <= PH_OPEN;
      endcase
    end
  end

  // R4: turn-off while on starts a blanking window
  a_r4_enter_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ON && sw_off && !fire) |=> in_blank);

  // R4: window length never exceeds the longest setting
  a_r4_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    in_blank |-> (int'(cnt) < BLANK_MAX));

  // R5: a window that is open stays open until a turn-on
  a_r5_open_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (win_open && !fire) |=> win_open);

endmodule

// File: rtl/qrt_starter.sv
module qrt_starter
  import qrt_pkg::*;
#(
  parameter int CODE_W     = 8,
  parameter int BURST_CODE = 77,
  parameter int START_FAST = 1250,
  parameter int START_SLOW = 5000,
  parameter int MIN_GAP    = 61
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [CODE_W-1:0] code,
  output logic              st_fire,
  output logic              gap_ok
);
  localparam int SCW = $clog2(START_SLOW + 1);

  logic [SCW-1:0] cnt;
  logic [SCW-1:0] per_m1;

  always_comb begin
    per_m1  = SCW'(starter_len(int'(code), BURST_CODE, START_FAST, START_SLOW) - 1);
    st_fire = (cnt >= per_m1);
    gap_ok  = (cnt >= SCW'(MIN_GAP - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (fire) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  // R7: the timer restarts on every turn-on
  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cnt == '0));

  // R7: the timer never runs past the slow period
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) < START_SLOW);

endmodule

// File: rtl/qr_turnon_ctrl.sv
module qr_turnon_ctrl #(
  parameter int CODE_W        = 8,
  parameter int BLANK_LO_CODE = 70,
  parameter int BLANK_HI_CODE = 100,
  parameter int BLANK_MAX     = 300,
  parameter int BLANK_MIN     = 60,
  parameter int BURST_CODE    = 77,
  parameter int START_FAST    = 1250,
  parameter int START_SLOW    = 5000,
  parameter int MIN_GAP       = 61
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dmg_arm_hi,
  input  logic              dmg_trig_hi,
  input  logic [CODE_W-1:0] ctrl_code,
  input  logic              sw_off,
  output logic              ton_req,
  output logic              valley_skip
);
  localparam int GW = $clog2(MIN_GAP + 1);

  logic armed, rise_ev, fall_ev;
  logic win_open, in_blank;
  logic st_fire, gap_ok;
  logic edge_take, skip_now, fire;
  logic skip_seen;

  qrt_edge_arm u_edge (
    .clk(clk), .rst_n(rst_n), .arm_lvl(dmg_arm_hi), .trig_lvl(dmg_trig_hi),
    .fire(fire), .armed(armed), .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  qrt_blank_timer #(
    .CODE_W(CODE_W), .BLANK_LO_CODE(BLANK_LO_CODE), .BLANK_HI_CODE(BLANK_HI_CODE),
    .BLANK_MAX(BLANK_MAX), .BLANK_MIN(BLANK_MIN)
  ) u_blank (
    .clk(clk), .rst_n(rst_n), .fire(fire), .sw_off(sw_off), .code(ctrl_code),
    .win_open(win_open), .in_blank(in_blank)
  );

  qrt_starter #(
    .CODE_W(CODE_W), .BURST_CODE(BURST_CODE), .START_FAST(START_FAST),
    .START_SLOW(START_SLOW), .MIN_GAP(MIN_GAP)
  ) u_start (
    .clk(clk), .rst_n(rst_n), .fire(fire), .code(ctrl_code),
    .st_fire(st_fire), .gap_ok(gap_ok)
  );

  always_comb begin
    edge_take = fall_ev & armed & win_open & gap_ok;
    skip_now  = fall_ev & armed & in_blank;
    fire      = edge_take | st_fire;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ton_req     <= 1'b0;
      valley_skip <= 1'b0;
      skip_seen   <= 1'b0;
    end else begin
      ton_req <= fire;
      if (fire) begin
        valley_skip <= skip_seen | skip_now;
        skip_seen   <= 1'b0;
      end else if (skip_now) begin
        skip_seen   <= 1'b1;
      end
    end
  end

  // Independent spacing counter for the rate-cap check
  logic [GW-1:0] chk_gap;
  always_ff @(posedge clk) begin
    if (!rst_n)                         chk_gap <= '0;
    else if (ton_req)                   chk_gap <= '0;
    else if (int'(chk_gap) < MIN_GAP)   chk_gap <= chk_gap + 1'b1;
  end

  // R2: a request lasts a single cycle
  a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ton_req |=> !ton_req);

  // R5: an edge-caused request needed an open window and an armed trigger
  a_r5_edge_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    (ton_req && !$past(st_fire)) |-> $past(win_open && armed));

  // R6: the skip flag changes only together with a request
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ton_req |-> $stable(valley_skip));

  // R7: an expired starter always yields a request
  a_r7_starter_fires: assert property (@(posedge clk) disable iff (!rst_n)
    st_fire |=> ton_req);

  // R8: requests keep the minimum spacing
  a_r8_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ton_req |-> (int'(chk_gap) >= MIN_GAP - 1));

endmodule

// File: tb/tb_qr_turnon_ctrl.sv
module tb_qr_turnon_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       arm_hi = 1'b0;
  logic       trig_hi = 1'b0;
  logic [7:0] code = 8'd200;
  logic       sw_off = 1'b0;
  logic       ton_req, valley_skip;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int n_ton = 0;
  int ton_cyc = 0;

  qr_turnon_ctrl dut (
    .clk(clk), .rst_n(rst_n), .dmg_arm_hi(arm_hi), .dmg_trig_hi(trig_hi),
    .ctrl_code(code), .sw_off(sw_off), .ton_req(ton_req), .valley_skip(valley_skip)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (ton_req) begin n_ton = n_ton + 1; ton_cyc = cyc; end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_blank(input int c);
    if (c <= 70) return 300;
    if (c >= 100) return 60;
    return 60 + (100 - c) * 8;
  endfunction

  // Turn-off pulse; returns at j = 0 (just after the edge that sampled it)
  task automatic turn_off();
    sw_off = 1'b1; tick(1); sw_off = 1'b0;
  endtask

  task automatic t_reset();
    tick(3);
    chk(ton_req == 1'b0, "R1 ton during reset", ton_req, 0);
    rst_n = 1'b1; tick(1);
    chk(ton_req == 1'b0 && valley_skip == 1'b0, "R1 outputs after reset",
        {ton_req, valley_skip}, 0);
  endtask

  task automatic t_gap_after_reset();
    arm_hi = 1'b1; trig_hi = 1'b1; tick(1);
    trig_hi = 1'b0; tick(20);
    chk(n_ton == 0, "R8 early edge after reset", n_ton, 0);
  endtask

  task automatic t_basic();
    tick(60);
    trig_hi = 1'b1; tick(1);
    trig_hi = 1'b0; tick(1);
    chk(ton_req == 1'b1, "R2 turn-on after armed fall", ton_req, 1);
    tick(1);
    chk(ton_req == 1'b0, "R2 single cycle", ton_req, 0);
    chk(n_ton == 1, "R2 pulse count", n_ton, 1);
    chk(valley_skip == 1'b0, "R6 no skip first cycle", valley_skip, 0);
  endtask

  task automatic t_unarmed();
    int c0;
    turn_off(); tick(70);
    c0 = n_ton;
    trig_hi = 1'b1; tick(1); trig_hi = 1'b0; tick(10);
    chk(n_ton == c0, "R3 fall while disarmed", n_ton - c0, 0);
  endtask

  task automatic t_on_phase();
    int c0;
    arm_hi = 1'b0; tick(1);
    arm_hi = 1'b1; trig_hi = 1'b1; tick(1);
    trig_hi = 1'b0; tick(1);
    chk(ton_req == 1'b1, "R3 rearm then fire", ton_req, 1);
    c0 = n_ton;
    arm_hi = 1'b0; trig_hi = 1'b1; tick(1);
    arm_hi = 1'b1; tick(1);
    trig_hi = 1'b0; tick(10);
    chk(n_ton == c0, "R5 fall while switch on", n_ton - c0, 0);
    arm_hi = 1'b0;
  endtask

  task automatic t_blank(input int c);
    int l = exp_blank(c);
    int c0;
    code = c[7:0];
    turn_off();
    c0 = n_ton;
    arm_hi = 1'b0; trig_hi = 1'b1; tick(1);
    arm_hi = 1'b1; tick(l - 3);
    trig_hi = 1'b0; tick(1);
    trig_hi = 1'b1; tick(1);
    trig_hi = 1'b0;
    chk(n_ton == c0, $sformatf("R4 blanked fall code %0d", c), n_ton - c0, 0);
    tick(1);
    chk(ton_req == 1'b1, $sformatf("R5 first fall after window code %0d", c), ton_req, 1);
    chk(valley_skip == 1'b1, $sformatf("R6 skip flagged code %0d", c), valley_skip, 1);
    arm_hi = 1'b0;
  endtask

  task automatic t_clean();
    int l = exp_blank(200);
    code = 8'd200;
    turn_off();
    arm_hi = 1'b0; trig_hi = 1'b1; tick(1);
    arm_hi = 1'b1; tick(l + 2);
    chk(valley_skip == 1'b1, "R6 flag held between turn-ons", valley_skip, 1);
    trig_hi = 1'b0; tick(1);
    chk(ton_req == 1'b1, "R5 clean turn-on", ton_req, 1);
    chk(valley_skip == 1'b0, "R6 flag cleared", valley_skip, 0);
    arm_hi = 1'b0;
  endtask

  task automatic wait_ton(input int limit);
    int c0 = n_ton;
    for (int i = 0; i < limit && n_ton == c0; i++) tick(1);
  endtask

  task automatic t_starter();
    int t0;
    t0 = ton_cyc; turn_off(); wait_ton(6000);
    chk(ton_cyc - t0 == 1250, "R7 fast starter period", ton_cyc - t0, 1250);
    code = 8'd77; t0 = ton_cyc; turn_off(); wait_ton(6000);
    chk(ton_cyc - t0 == 5000, "R7 slow starter at burst code", ton_cyc - t0, 5000);
    code = 8'd78; t0 = ton_cyc; turn_off(); wait_ton(6000);
    chk(ton_cyc - t0 == 1250, "R7 fast starter above burst code", ton_cyc - t0, 1250);
    turn_off(); tick(400);
    arm_hi = 1'b1; trig_hi = 1'b1; tick(1);
    trig_hi = 1'b0; tick(1);
    chk(ton_req == 1'b1, "R7 edge turn-on mid period", ton_req, 1);
    t0 = ton_cyc; arm_hi = 1'b0; turn_off(); wait_ton(6000);
    chk(ton_cyc - t0 == 1250, "R7 timer restarted by edge", ton_cyc - t0, 1250);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_gap_after_reset();
    t_basic();
    t_unarmed();
    t_on_phase();
    t_blank(200);
    t_blank(100);
    t_blank(99);
    t_blank(85);
    t_blank(71);
    t_blank(70);
    t_blank(20);
    t_clean();
    t_starter();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule